// File: doc/BRIEF.md
# Flash Operation Status Readback Multiplexer

This block sits on the read path of a byte-wide flash array. While an internal program or erase operation is in flight, a host cannot read the array. Instead it polls the device, and each read returns a status byte. Bit 7 carries a polling flag tied to the data being written. Bit 6 flips on every read until the operation ends. When the device is idle, reads return the array contents unchanged.

In identification mode, the block returns a small set of fixed codes from the first bytes of the boot sector instead of array data. The third byte of the boot sector reports whether writes to that sector are locked. The boot sector can be placed at the bottom or at the top of the address space, and a parameter selects which.

Read data is registered. It updates on the clock edge that samples `rd_strobe_i` and holds between reads.

Top module: `flash_status_rb`

## Requirements
- R1: After reset, `rd_data_o` is 0x00.
- R2: During a program operation (`busy_i`=1, `op_erase_i`=0), a read returns the inverse of bit 7 of `last_byte_i` on bit 7.
- R3: During an erase operation (`busy_i`=1, `op_erase_i`=1), a read returns 0 on bit 7, the inverse of the erased value 1.
- R4: Bit 6 of the first busy read after `busy_i` rises is 0. Each later busy read within the same operation returns the inverse of the previous read's bit 6.
- R5: On every busy read, bits 5 to 0 are 0.
- R6: When `busy_i`=0 and `id_mode_i`=0, a read returns `array_data_i` on all eight bits.
- R7: When idle in identification mode, a read at boot base + 2 returns {7'b0, `lockout_i`}. Bit 0 is 1 when the sector is locked.
- R8: When idle in identification mode, a read at boot base + 0 returns MFR_CODE and a read at boot base + 1 returns DEV_CODE. Every other address returns 0x00.
- R9: In a cycle with `rd_strobe_i`=0, `rd_data_o` keeps its value.
- R10: The boot base is 0 when BOOT_AT_TOP=0. When BOOT_AT_TOP=1, the boot base is 2^ADDR_W − BOOT_BYTES.
- R11: `rd_data_o` changes one clock after the edge that samples `rd_strobe_i`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| busy_i | input | 1 | Internal operation in progress |
| op_erase_i | input | 1 | 1 = current operation is an erase, 0 = a program |
| last_byte_i | input | 8 | Byte most recently loaded for programming |
| array_data_i | input | 8 | Array read data |
| rd_strobe_i | input | 1 | Read request, one cycle per read |
| id_mode_i | input | 1 | Identification mode active |
| lockout_i | input | 1 | Boot sector write lockout state |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | 8 | Registered read data |

## Verification
The bench builds the block with ADDR_W=18, a 16 KiB boot sector and BOOT_AT_TOP=1. With these values, the identification codes sit at 0x3C000 to 0x3C002. Reads at the low addresses 0x00000 to 0x00002 must return zero, which shows the parameter really moves the decode. A program operation and an erase operation run back to back. Reads are spaced irregularly and separated by strobe-free cycles, so the toggle restart, the polarity of bit 7 and the hold behaviour are all reached.

// File: rtl/status_rb_pkg.sv
package status_rb_pkg;

    typedef struct packed {
        logic [7:0] rd_data;
        logic       tog;
        logic       busy_prev;
    } rb_state_t;

    localparam int unsigned POLL_BIT = 7;
    localparam int unsigned TOG_BIT  = 6;

endpackage

// File: rtl/srb_poll_gen.sv
module srb_poll_gen (
    input  logic       op_erase_i,
    input  logic [7:0] last_byte_i,
    input  logic       tog_i,
    output logic [7:0] status_o
);
    import status_rb_pkg::*;

    always_comb begin
        status_o = 8'h00;
        // Erased cells read 1, so the erase polling flag is its inverse.
        status_o[POLL_BIT] = op_erase_i ? 1'b0 : ~last_byte_i[7];
        status_o[TOG_BIT]  = tog_i;
    end
endmodule

// File: rtl/srb_id_gen.sv
module srb_id_gen #(
    parameter int unsigned ADDR_W      = 18,
    parameter int unsigned BOOT_BYTES  = 16384,
    parameter bit          BOOT_AT_TOP = 1'b0,
    parameter logic [7:0]  MFR_CODE    = 8'h1F,
    parameter logic [7:0]  DEV_CODE    = 8'h07
) (
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic              lockout_i,
    output logic [7:0]        id_o
);
    localparam longint unsigned SPAN = 64'd1 << ADDR_W;

    logic [ADDR_W-1:0] base;

    generate
        if (BOOT_AT_TOP) begin : g_top
            assign base = ADDR_W'(SPAN - 64'(BOOT_BYTES));
        end else begin : g_bottom
            assign base = '0;
        end
    endgenerate

    always_comb begin
        id_o = 8'h00;
        if (rd_addr_i == base) begin
            id_o = MFR_CODE;
        end else if (rd_addr_i == base + ADDR_W'(1)) begin
            id_o = DEV_CODE;
        end else if (rd_addr_i == base + ADDR_W'(2)) begin
            id_o = {7'b0, lockout_i};
        end
    end
endmodule

// File: rtl/flash_status_rb.sv
module flash_status_rb #(
    parameter int unsigned ADDR_W      = 18,
    parameter int unsigned BOOT_BYTES  = 16384,
    parameter bit          BOOT_AT_TOP = 1'b0,
    parameter logic [7:0]  MFR_CODE    = 8'h1F,
    parameter logic [7:0]  DEV_CODE    = 8'h07
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              busy_i,
    input  logic              op_erase_i,
    input  logic [7:0]        last_byte_i,
    input  logic [7:0]        array_data_i,
    input  logic              rd_strobe_i,
    input  logic              id_mode_i,
    input  logic              lockout_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [7:0]        rd_data_o
);
    import status_rb_pkg::*;

    rb_state_t  st_d, st_q;
    logic       op_start;
    logic       tog_now;
    logic [7:0] status_byte;
    logic [7:0] id_byte;

    // A rising busy_i marks a new operation, which restarts the toggle.
    assign op_start = busy_i & ~st_q.busy_prev;
    assign tog_now  = op_start ? 1'b0 : st_q.tog;

    srb_poll_gen poll_i (
        .op_erase_i  (op_erase_i),
        .last_byte_i (last_byte_i),
        .tog_i       (tog_now),
        .status_o    (status_byte)
    );

    srb_id_gen #(
        .ADDR_W      (ADDR_W),
        .BOOT_BYTES  (BOOT_BYTES),
        .BOOT_AT_TOP (BOOT_AT_TOP),
        .MFR_CODE    (MFR_CODE),
        .DEV_CODE    (DEV_CODE)
    ) id_i (
        .rd_addr_i (rd_addr_i),
        .lockout_i (lockout_i),
        .id_o      (id_byte)
    );

    always_comb begin
        st_d           = st_q;
        st_d.busy_prev = busy_i;
        st_d.tog       = tog_now;
        if (rd_strobe_i) begin
            if (busy_i) begin
                st_d.rd_data = status_byte;
                st_d.tog     = ~tog_now;
            end else if (id_mode_i) begin
                st_d.rd_data = id_byte;
            end else begin
                st_d.rd_data = array_data_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.rd_data;
endmodule

// File: rtl/srb_checker.sv
module srb_checker #(
    parameter int unsigned ADDR_W      = 18,
    parameter int unsigned BOOT_BYTES  = 16384,
    parameter bit          BOOT_AT_TOP = 1'b0
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              busy_i,
    input logic              op_erase_i,
    input logic [7:0]        last_byte_i,
    input logic [7:0]        array_data_i,
    input logic              rd_strobe_i,
    input logic              id_mode_i,
    input logic              lockout_i,
    input logic [ADDR_W-1:0] rd_addr_i,
    input logic [7:0]        rd_data_o
);
    localparam longint unsigned SPAN = 64'd1 << ADDR_W;
    localparam logic [ADDR_W-1:0] LOCK_ADDR =
        BOOT_AT_TOP ? ADDR_W'(SPAN - 64'(BOOT_BYTES) + 64'd2) : ADDR_W'(2);

    // Set once a busy read has happened in the current operation.
    logic seen_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni)      seen_q <= 1'b0;
        else if (!busy_i) seen_q <= 1'b0;
        else if (rd_strobe_i) seen_q <= 1'b1;
    end

    a_r1_reset_zero: assert property (@(posedge clk_i)
        !rst_ni |=> rd_data_o == 8'h00);

    a_r2_program_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && rd_strobe_i && !op_erase_i |=> rd_data_o[7] == ~$past(last_byte_i[7]));

    a_r3_erase_poll: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && rd_strobe_i && op_erase_i |=> rd_data_o[7] == 1'b0);

    a_r4_toggle_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && rd_strobe_i && !seen_q |=> rd_data_o[6] == 1'b0);

    a_r4_toggle_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && rd_strobe_i && seen_q |=> rd_data_o[6] != $past(rd_data_o[6]));

    a_r5_low_bits_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_i && rd_strobe_i |=> rd_data_o[5:0] == 6'd0);

    a_r6_array_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i && !id_mode_i && rd_strobe_i |=> rd_data_o == $past(array_data_i));

    a_r7_lock_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i && id_mode_i && rd_strobe_i && rd_addr_i == LOCK_ADDR
        |=> rd_data_o == {7'b0, $past(lockout_i)});

    a_r9_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni && !rd_strobe_i |=> $stable(rd_data_o));
endmodule

bind flash_status_rb srb_checker #(
    .ADDR_W      (ADDR_W),
    .BOOT_BYTES  (BOOT_BYTES),
    .BOOT_AT_TOP (BOOT_AT_TOP)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .busy_i       (busy_i),
    .op_erase_i   (op_erase_i),
    .last_byte_i  (last_byte_i),
    .array_data_i (array_data_i),
    .rd_strobe_i  (rd_strobe_i),
    .id_mode_i    (id_mode_i),
    .lockout_i    (lockout_i),
    .rd_addr_i    (rd_addr_i),
    .rd_data_o    (rd_data_o)
);

// File: tb/flash_status_rb_tb.sv
`timescale 1ns/1ps
module flash_status_rb_tb_top;
    localparam int ADDR_W = 18;
    localparam int BOOT_BYTES = 16384;
    localparam logic [7:0] MFR = 8'h1F;
    localparam logic [7:0] DEV = 8'h07;
    localparam int BASE = (1 << ADDR_W) - BOOT_BYTES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic busy = 1'b0, erase = 1'b0, rd = 1'b0, idm = 1'b0, lock = 1'b0;
    logic [7:0] last_b = 8'h00, arr = 8'h00;
    logic [ADDR_W-1:0] addr = '0;
    logic [7:0] rd_data;

    always #2.5 clk = ~clk;

    flash_status_rb #(
        .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .BOOT_AT_TOP(1'b1),
        .MFR_CODE(MFR), .DEV_CODE(DEV)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .op_erase_i(erase),
        .last_byte_i(last_b), .array_data_i(arr), .rd_strobe_i(rd),
        .id_mode_i(idm), .lockout_i(lock), .rd_addr_i(addr), .rd_data_o(rd_data)
    );

    int errors = 0;
    int checks = 0;
    string tag = "R1";
    bit done = 0;

    // Behavioural reference: expected read byte and toggle parity per operation.
    int exp_byte = 0;
    int reads_in_op = 0;
    bit was_busy = 0;

    function automatic int id_value(int a, bit lk);
        if (a == BASE)     return MFR;
        if (a == BASE + 1) return DEV;
        if (a == BASE + 2) return lk ? 1 : 0;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            exp_byte = 0; reads_in_op = 0; was_busy = 0;
        end else begin
            if (busy && !was_busy) reads_in_op = 0;
            if (rd) begin
                if (busy) begin
                    exp_byte = ((erase ? 0 : (last_b[7] ? 0 : 1)) * 128)
                             + ((reads_in_op % 2) * 64);
                    reads_in_op++;
                end else if (idm) begin
                    exp_byte = id_value(int'(addr), lock);
                end else begin
                    exp_byte = int'(arr);
                end
            end
            was_busy = busy;
        end
    end

    // Every-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(rd_data) != exp_byte) begin
                errors++;
                $display("FAIL %s: rd_data=%02h expected=%02h at %0t", tag, rd_data, exp_byte[7:0], $time);
            end
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_read(logic [ADDR_W-1:0] a, logic [7:0] ad, logic [7:0] lb);
        addr = a; arr = ad; last_b = lb; rd = 1'b1;
        step(1);
        rd = 1'b0;
    endtask

    task automatic expect_byte(string req, logic [7:0] e);
        checks++;
        if (rd_data !== e) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h", req, rd_data, e);
        end
    endtask

    initial begin : watchdog
        #(5ns * 20000);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        step(3);
        expect_byte("R1", 8'h00);
        rst_n = 1'b1;
        step(1);

        tag = "R6";
        do_read('0, 8'hA5, 8'h00); step(1); expect_byte("R6", 8'hA5);
        do_read(18'h12345, 8'h3C, 8'h00); expect_byte("R11", 8'h3C);

        tag = "R9";
        arr = 8'hFF; step(4); expect_byte("R9", 8'h3C);

        // Program operation: polling bit, toggle from 0, low bits clear.
        tag = "R2";
        busy = 1'b1; erase = 1'b0; step(2);
        do_read(18'h00100, 8'hEE, 8'h80); expect_byte("R2 R4 R5", 8'h00);
        step(3); expect_byte("R9", 8'h00);
        do_read(18'h00100, 8'hEE, 8'h7F); expect_byte("R2 R4", 8'hC0);
        do_read(18'h00100, 8'hEE, 8'h7F); expect_byte("R4", 8'h80);
        do_read(18'h00100, 8'hEE, 8'h80); expect_byte("R4", 8'h40);
        busy = 1'b0; step(1);
        tag = "R6";
        do_read(18'h00100, 8'h5A, 8'h00); expect_byte("R6", 8'h5A);

        // Erase operation: polling bit 0, toggle restarts at 0.
        tag = "R3";
        busy = 1'b1; erase = 1'b1;
        do_read(18'h20000, 8'h11, 8'h00); expect_byte("R3 R4", 8'h00);
        do_read(18'h20000, 8'h11, 8'hFF); expect_byte("R3 R4 R5", 8'h40);
        step(2);
        do_read(18'h20000, 8'h11, 8'h00); expect_byte("R4", 8'h00);
        busy = 1'b0; erase = 1'b0; step(1);
        do_read(18'h20000, 8'hFF, 8'h00); expect_byte("R6", 8'hFF);

        // Identification mode with the boot sector at the top.
        tag = "R8";
        idm = 1'b1; lock = 1'b0;
        do_read(18'h3C000, 8'h99, 8'h00); expect_byte("R8 R10", MFR);
        do_read(18'h3C001, 8'h99, 8'h00); expect_byte("R8", DEV);
        tag = "R7";
        do_read(18'h3C002, 8'h99, 8'h00); expect_byte("R7", 8'h00);
        lock = 1'b1;
        do_read(18'h3C002, 8'h99, 8'h00); expect_byte("R7", 8'h01);
        tag = "R10";
        do_read(18'h00002, 8'h99, 8'h00); expect_byte("R10", 8'h00);
        do_read(18'h00000, 8'h99, 8'h00); expect_byte("R10", 8'h00);
        do_read(18'h3C003, 8'h99, 8'h00); expect_byte("R8", 8'h00);
        idm = 1'b0;
        tag = "R6";
        do_read(18'h3C002, 8'h77, 8'h00); expect_byte("R6", 8'h77);

        tag = "R1";
        rst_n = 1'b0; step(1); expect_byte("R1", 8'h00);
        rst_n = 1'b1; step(1);

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule